// File: doc/BRIEF.md
# External Sync Lock and Vertical Reset Controller

This block sits beside the horizontal and vertical counters of a camera sync generator. It watches three inputs: a vertical reference pin that may carry a composite sync or a vertical drive, a horizontal reference pin, and a mode strap. From the levels and edges on these pins it decides whether the generator runs free, locks to an external composite sync, or locks to separate external vertical and horizontal drives. It reports that decision on a lock flag and a two-bit kind code. Whenever the block is locked, it sends a one-cycle reset pulse to the vertical counter so that the generator's own vertical drive lines up with the reference.

In composite mode the vertical interval is found by measuring how long the sync stays low. A low run that lasts at least `BROAD_CLKS` clocks is a vertical event. The reset is then issued a standard-dependent number of lines later. In separate-drive mode the reset follows the falling edge of the external vertical drive by one line. The same edge also sets field parity, which depends on whether the edge lands in the first or the second half of the locked line. Line timing arrives as a one-cycle `hd_tick_i` at each line start and as `h_late_i`, which is high for the second half of each line. `std625_i` and `nonint_i` are static configuration levels and are not synchronized.

The controller is a five-state machine:
- `ST_FREE` is free running.
- `ST_CS_WAIT` and `ST_CS_COUNT` wait for a composite vertical event and then count lines.
- `ST_VH_WAIT` and `ST_VH_COUNT` wait for an external vertical fall and then count lines.

Its transitions are:
- *enter-composite*: FREE to CS_WAIT.
- *enter-drive*: FREE to VH_WAIT.
- *accept*: CS_WAIT to CS_COUNT, and VH_WAIT to VH_COUNT.
- *fire*: CS_COUNT to CS_WAIT, and VH_COUNT to VH_WAIT. This is the cycle before the reset pulse.
- *break*: any locked state to FREE, on a pin-pattern change.
- *loss*: either wait state to FREE, on reference timeout.

Top module: `extsync_vreset`

## Requirements
- R1: After reset, `ext_lock_o`=0, `sync_kind_o`=00, `vreset_o`=0 and `field_odd_o`=1.
- R2: With every reference pin at its pull level (vertical high, horizontal high, mode low), the block stays in free running. It reports kind 00 with the lock flag low and issues no reset pulse.
- R3: A pin is active when the older of its last two edges lies within one frame of lines (F525 or F625). An active vertical pin with an inactive horizontal pin, mode low and `nonint_i` low selects composite lock: kind 01, lock flag high.
- R4: While `nonint_i` is high, composite lock is never entered, even when a valid composite sync is present.
- R5: Active vertical and horizontal pins with mode high select separate-drive lock: kind 10, lock flag high.
- R6: Low pulses shorter than `BROAD_CLKS` clocks are not vertical events and cause no reset.
- R7: In composite lock, `vreset_o` is high for one cycle, in the cycle after the D525th `hd_tick_i` following the vertical event (D625th when `std625_i`=1). Further events during that count are ignored.
- R8: In separate-drive lock, `vreset_o` pulses in the cycle after the first `hd_tick_i` that follows an accepted vertical fall.
- R9: An accepted vertical fall sets `field_odd_o` to 1 if `h_late_i` is low at acceptance and to 0 if it is high. The value is held at all other times.
- R10: If no vertical event is accepted for more than two frames of lines, the block returns to free running with the lock flag low and `field_odd_o` unchanged.
- R11: In separate-drive lock, driving the mode pin low returns the block to free running.
- R12: Separate-drive lock holds, and resets on every vertical fall, when the vertical period is longer than one frame but at most two frames.
- R13: If a vertical fall is accepted in the same cycle as `hd_tick_i`, that tick does not count toward the reset delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| std625_i | input | 1 | 1 selects the 625-line standard, 0 the 525-line one |
| nonint_i | input | 1 | 1 requests non-interlaced operation |
| vref_i | input | 1 | Composite sync or vertical drive reference, idles high |
| href_i | input | 1 | Horizontal drive reference, idles high |
| mode_i | input | 1 | Mode strap, idles low; high selects separate drives |
| hd_tick_i | input | 1 | One-cycle pulse at each internal line start |
| h_late_i | input | 1 | High during the second half of the internal line |
| ext_lock_o | output | 1 | High while locked to an external reference |
| sync_kind_o | output | 2 | 00 free, 01 composite, 10 separate drives |
| vreset_o | output | 1 | One-cycle vertical counter reset |
| field_odd_o | output | 1 | 1 odd field, 0 even field |

## Verification
The acceptance of an external vertical fall and the counting of a line tick can land in the same clock cycle. This collision decides whether the reset comes one line or two lines after the edge. The bench sweeps the fall offset through every clock position of the line. The offset that is two clocks before the line start makes the synchronized edge coincide exactly with the tick. There, the reset must come at the second following line start and the parity must read odd. Neighbouring offsets confirm the one-line delay and the half-line parity boundary.

// File: rtl/extsync_pkg.sv
package extsync_pkg;

    typedef enum logic [2:0] {
        ST_FREE     = 3'd0,
        ST_CS_WAIT  = 3'd1,
        ST_CS_COUNT = 3'd2,
        ST_VH_WAIT  = 3'd3,
        ST_VH_COUNT = 3'd4
    } lock_state_e;

    typedef enum logic [1:0] {
        KIND_INT   = 2'b00,
        KIND_CSYNC = 2'b01,
        KIND_VHD   = 2'b10
    } sync_kind_e;

endpackage

// File: rtl/extsync_sync.sv
module extsync_sync #(
    parameter int            W       = 3,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= RST_VAL;
            stage2_q <= RST_VAL;
        end else begin
            stage1_q <= d;
            stage2_q <= stage1_q;
        end
    end

    assign q = stage2_q;

endmodule

// File: rtl/extsync_activity.sv
module extsync_activity #(
    parameter int   AW       = 11,
    parameter logic IDLE_LVL = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_tick,
    input  logic          sig,
    input  logic [AW-1:0] window,
    output logic          active
);

    logic          prev_q;
    logic [AW-1:0] age_last_q;
    logic [AW-1:0] age_prev_q;
    logic          toggled;

    assign toggled = sig ^ prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q     <= IDLE_LVL;
            age_last_q <= '1;
            age_prev_q <= '1;
        end else begin
            prev_q <= sig;
            if (toggled) begin
                age_prev_q <= age_last_q;
                age_last_q <= '0;
            end else if (line_tick) begin
                if (age_last_q < window) age_last_q <= age_last_q + 1'b1;
                if (age_prev_q < window) age_prev_q <= age_prev_q + 1'b1;
            end
        end
    end

    assign active = (age_prev_q < window);

    // R3: the newest edge can never be older than the one before it
    a_r3_age_order: assert property (@(posedge clk) disable iff (!rst_n)
        age_last_q <= age_prev_q);

endmodule

// File: rtl/extsync_broad.sv
module extsync_broad #(
    parameter int BROAD_CLKS = 600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic long_evt,
    output logic fall
);

    localparam int BW = $clog2(BROAD_CLKS + 1);

    logic [BW-1:0] low_run_q;
    logic          prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run_q <= '0;
            prev_q    <= 1'b1;
        end else begin
            prev_q <= sig;
            if (sig)
                low_run_q <= '0;
            else if (low_run_q < BW'(BROAD_CLKS))
                low_run_q <= low_run_q + 1'b1;
        end
    end

    assign long_evt = !sig && (low_run_q == BW'(BROAD_CLKS - 1));
    assign fall     = prev_q && !sig;

    // R6: one vertical event per low run at most
    a_r6_one_evt_per_run: assert property (@(posedge clk) disable iff (!rst_n)
        long_evt |=> !long_evt);

endmodule

// File: rtl/extsync_ctrl.sv
module extsync_ctrl
    import extsync_pkg::*;
#(
    parameter int CW   = 11,
    parameter int D525 = 259,
    parameter int D625 = 309,
    parameter int DVH  = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_tick,
    input  logic          h_late,
    input  logic          std625,
    input  logic          nonint,
    input  logic          mode_hi,
    input  logic          vr_act,
    input  logic          hr_act,
    input  logic          long_evt,
    input  logic          vr_fall,
    input  logic [CW-1:0] window,
    output logic          status_ext,
    output logic [1:0]    sync_kind,
    output logic          vreset,
    output logic          field_odd
);

    lock_state_e   state_q, state_d;
    sync_kind_e    kind;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] loss_q;
    logic [CW-1:0] lim_loss;
    logic [CW-1:0] dly_last;
    logic          cs_ok, cs_break, vh_ok, vh_break;
    logic          loss_hit, accept, fire;
    logic          vreset_q, field_odd_q;

    assign lim_loss = window << 1;
    assign dly_last = std625 ? CW'(D625 - 1) : CW'(D525 - 1);
    assign cs_ok    = vr_act & ~hr_act & ~mode_hi & ~nonint;
    assign cs_break = hr_act | mode_hi | nonint;
    assign vh_ok    = vr_act & hr_act & mode_hi;
    assign vh_break = ~hr_act | ~mode_hi;
    assign loss_hit = line_tick && (loss_q >= lim_loss);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FREE: begin
                if (cs_ok)      state_d = ST_CS_WAIT;
                else if (vh_ok) state_d = ST_VH_WAIT;
            end
            ST_CS_WAIT: begin
                if (cs_break)      state_d = ST_FREE;
                else if (long_evt) state_d = ST_CS_COUNT;
                else if (loss_hit) state_d = ST_FREE;
            end
            ST_CS_COUNT: begin
                if (cs_break)                            state_d = ST_FREE;
                else if (line_tick && cnt_q == dly_last) state_d = ST_CS_WAIT;
            end
            ST_VH_WAIT: begin
                if (vh_break)      state_d = ST_FREE;
                else if (vr_fall)  state_d = ST_VH_COUNT;
                else if (loss_hit) state_d = ST_FREE;
            end
            ST_VH_COUNT: begin
                if (vh_break)                                  state_d = ST_FREE;
                else if (line_tick && cnt_q == CW'(DVH - 1))   state_d = ST_VH_WAIT;
            end
            default: state_d = ST_FREE;
        endcase
    end

    assign accept = ((state_q == ST_CS_WAIT) && (state_d == ST_CS_COUNT)) ||
                    ((state_q == ST_VH_WAIT) && (state_d == ST_VH_COUNT));
    assign fire   = ((state_q == ST_CS_COUNT) && (state_d == ST_CS_WAIT)) ||
                    ((state_q == ST_VH_COUNT) && (state_d == ST_VH_WAIT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FREE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            loss_q      <= '0;
            vreset_q    <= 1'b0;
            field_odd_q <= 1'b1;
        end else begin
            vreset_q <= fire;
            if (accept)
                cnt_q <= '0;
            else if (line_tick && (state_q == ST_CS_COUNT || state_q == ST_VH_COUNT))
                cnt_q <= cnt_q + 1'b1;
            if (state_q == ST_FREE || accept)
                loss_q <= '0;
            else if (line_tick && loss_q < lim_loss)
                loss_q <= loss_q + 1'b1;
            if (state_q == ST_VH_WAIT && state_d == ST_VH_COUNT)
                field_odd_q <= ~h_late;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_CS_WAIT, ST_CS_COUNT: kind = KIND_CSYNC;
            ST_VH_WAIT, ST_VH_COUNT: kind = KIND_VHD;
            default:                 kind = KIND_INT;
        endcase
    end

    assign sync_kind  = kind;
    assign status_ext = (kind != KIND_INT);
    assign vreset     = vreset_q;
    assign field_odd  = field_odd_q;

    // R7: the reset is a single-cycle pulse
    a_r7_vreset_single: assert property (@(posedge clk) disable iff (!rst_n)
        vreset_q |=> !vreset_q);

    // R8: a reset always follows a line tick
    a_r8_vreset_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        vreset_q |-> $past(line_tick));

    // R2: free running never produces a reset
    a_r2_free_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FREE) |=> !vreset_q);

    // R9: parity moves only when a vertical fall is accepted
    a_r9_parity_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(state_q == ST_VH_WAIT && vr_fall) |=> $stable(field_odd_q));

endmodule

// File: rtl/extsync_vreset.sv
module extsync_vreset #(
    parameter int F525       = 525,
    parameter int F625       = 625,
    parameter int D525       = 259,
    parameter int D625       = 309,
    parameter int DVH        = 1,
    parameter int BROAD_CLKS = 600
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       std625_i,
    input  logic       nonint_i,
    input  logic       vref_i,
    input  logic       href_i,
    input  logic       mode_i,
    input  logic       hd_tick_i,
    input  logic       h_late_i,
    output logic       ext_lock_o,
    output logic [1:0] sync_kind_o,
    output logic       vreset_o,
    output logic       field_odd_o
);

    localparam int NCH = 2;
    localparam int CW  = $clog2(2 * F625 + 2);

    logic [2:0]     pins_s;
    logic           vref_s, href_s, mode_s;
    logic [NCH-1:0] chan_sig;
    logic [NCH-1:0] chan_act;
    logic [CW-1:0]  window;
    logic           long_evt, vr_fall;

    extsync_sync #(.W(3), .RST_VAL(3'b011)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({mode_i, href_i, vref_i}),
        .q     (pins_s)
    );

    assign vref_s   = pins_s[0];
    assign href_s   = pins_s[1];
    assign mode_s   = pins_s[2];
    assign chan_sig = {href_s, vref_s};
    assign window   = std625_i ? CW'(F625) : CW'(F525);

    for (genvar g = 0; g < NCH; g++) begin : g_act
        extsync_activity #(.AW(CW), .IDLE_LVL(1'b1)) u_act (
            .clk       (clk),
            .rst_n     (rst_n),
            .line_tick (hd_tick_i),
            .sig       (chan_sig[g]),
            .window    (window),
            .active    (chan_act[g])
        );
    end

    extsync_broad #(.BROAD_CLKS(BROAD_CLKS)) u_broad (
        .clk      (clk),
        .rst_n    (rst_n),
        .sig      (vref_s),
        .long_evt (long_evt),
        .fall     (vr_fall)
    );

    extsync_ctrl #(.CW(CW), .D525(D525), .D625(D625), .DVH(DVH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_tick  (hd_tick_i),
        .h_late     (h_late_i),
        .std625     (std625_i),
        .nonint     (nonint_i),
        .mode_hi    (mode_s),
        .vr_act     (chan_act[0]),
        .hr_act     (chan_act[1]),
        .long_evt   (long_evt),
        .vr_fall    (vr_fall),
        .window     (window),
        .status_ext (ext_lock_o),
        .sync_kind  (sync_kind_o),
        .vreset     (vreset_o),
        .field_odd  (field_odd_o)
    );

endmodule

// File: tb/sim_extsync_vreset.sv
module sim_extsync_vreset;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       std625, nonint, vref, href, mode, hd_tick, h_late;
    logic       ext_lock, vreset, fodd;
    logic [1:0] kind;
    logic       href_on;
    int         n_chk = 0;
    int         n_err = 0;
    int         line_no = 0;
    int         vr_cnt = 0;
    int         vr_line = -1;
    bit         done = 0;

    always #5 clk = ~clk;

    extsync_vreset #(
        .F525(21), .F625(25), .D525(9), .D625(11), .DVH(1), .BROAD_CLKS(6)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .std625_i(std625), .nonint_i(nonint),
        .vref_i(vref), .href_i(href), .mode_i(mode), .hd_tick_i(hd_tick),
        .h_late_i(h_late), .ext_lock_o(ext_lock), .sync_kind_o(kind),
        .vreset_o(vreset), .field_odd_o(fodd)
    );

    always @(negedge clk) begin
        if (vreset === 1'b1) begin
            vr_cnt  = vr_cnt + 1;
            vr_line = line_no;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // vpat: 0 high, 1 short sync, 2 broad sync, 3 falls at voff, 4 low
    task automatic do_line(input int vpat, input int voff);
        line_no++;
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            hd_tick = (k == 0);
            h_late  = (k >= 8);
            case (vpat)
                1:       vref = !(k >= 2 && k <= 3);
                2:       vref = !(k >= 2 && k <= 11);
                3:       vref = (k < voff);
                4:       vref = 1'b0;
                default: vref = 1'b1;
            endcase
            href = href_on ? !(k == 4 || k == 5) : 1'b1;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; std625 = 1'b0; nonint = 1'b0; vref = 1'b1; href = 1'b1;
        mode = 1'b0; hd_tick = 1'b0; h_late = 1'b0; href_on = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        vr_cnt = 0;
        vr_line = -1;
    endtask

    task automatic prime_vh();
        mode = 1'b1; href_on = 1'b1;
        do_line(0, 0); do_line(0, 0);
        do_line(3, 3); do_line(4, 0); do_line(4, 0);
        do_line(0, 0); do_line(0, 0);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int base, c0;
        do_reset();
        @(negedge clk);
        check("R1 lock", ext_lock, 0);
        check("R1 kind", kind, 0);
        check("R1 vreset", vreset, 0);
        check("R1 field", fodd, 1);

        repeat (25) do_line(0, 0);
        check("R2 lock", ext_lock, 0);
        check("R2 kind", kind, 0);
        check("R2 resets", vr_cnt, 0);

        nonint = 1'b1;
        repeat (4) do_line(1, 0);
        repeat (3) do_line(2, 0);
        repeat (4) do_line(1, 0);
        check("R4 lock", ext_lock, 0);
        check("R4 resets", vr_cnt, 0);

        nonint = 1'b0;
        repeat (2) do_line(1, 0);
        check("R3 kind", kind, 1);
        check("R3 lock", ext_lock, 1);

        repeat (12) do_line(1, 0);
        check("R6 resets", vr_cnt, 0);

        c0 = vr_cnt;
        do_line(2, 0); base = line_no;
        do_line(2, 0); do_line(2, 0);
        while (line_no < base + 14) do_line(1, 0);
        check("R7 count 525", vr_cnt - c0, 1);
        check("R7 delay 525", vr_line - base, 9);

        std625 = 1'b1;
        c0 = vr_cnt;
        do_line(2, 0); base = line_no;
        do_line(2, 0); do_line(2, 0);
        while (line_no < base + 16) do_line(1, 0);
        check("R7 count 625", vr_cnt - c0, 1);
        check("R7 delay 625", vr_line - base, 11);

        do_reset();
        prime_vh();
        check("R5 kind", kind, 2);
        check("R5 lock", ext_lock, 1);

        for (int off = 0; off < 16; off++) begin
            int b, c;
            c = vr_cnt;
            do_line(3, off); b = line_no;
            do_line(4, 0); do_line(4, 0); do_line(0, 0); do_line(0, 0);
            check("R8 count", vr_cnt - c, 1);
            if (off >= 14) check("R13 delay", vr_line - b, 2);
            else           check("R8 delay", vr_line - b, 1);
            check("R9 parity", fodd, (off < 6 || off >= 14) ? 1 : 0);
        end

        for (int rep = 0; rep < 3; rep++) begin
            int b, c;
            c = vr_cnt;
            do_line(3, 3); b = line_no;
            do_line(4, 0); do_line(4, 0);
            repeat (27) do_line(0, 0);
            check("R12 count", vr_cnt - c, 1);
            check("R12 delay", vr_line - b, 1);
            check("R12 lock", ext_lock, 1);
        end

        do_line(3, 11); base = line_no;
        do_line(4, 0); do_line(4, 0);
        while (line_no < base + 42) do_line(0, 0);
        check("R10 still locked", ext_lock, 1);
        do_line(0, 0);
        check("R10 lock lost", ext_lock, 0);
        check("R10 kind", kind, 0);
        check("R10 parity kept", fodd, 0);

        do_reset();
        prime_vh();
        mode = 1'b0;
        do_line(0, 0);
        check("R11 lock", ext_lock, 0);
        check("R11 kind", kind, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule